// File: doc/BRIEF.md
# In-Order Retirement Queue

This block is a circular buffer that tracks renamed instructions from the moment rename hands them over until they leave the machine. Rename asks for one slot per instruction. It supplies the destination architectural register, the newly chosen physical register and the physical register that held the old mapping. It also marks whether the instruction is a store and whether it was already finished at rename: zeroing idioms and eliminated moves need no execution. The block answers with the slot index. Execution units later report completion by that index.

Retirement is strictly in program order. Only the oldest occupied slot may leave, and only once it is complete. A younger finished instruction waits behind an unfinished older one. When the oldest slot retires, the block does three things in the same cycle:
- it presents the architectural register together with its new physical mapping, so the committed map can be updated;
- it hands back the old physical register for the free pool;
- for a store, it raises a release strobe so the memory write may proceed.

The slot is then cleared and can be reused.

Top module: `rtq_top`

## Requirements
- R1: Out of reset the queue is empty: `retValid` and `storeGo` are low, and the first allocation is granted slot index 0.
- R2: Each granted allocation returns the current tail index on `allocIdx` in the same cycle. Successive grants return consecutive indices modulo DEPTH.
- R3: When DEPTH slots are occupied, `allocGrant` stays low and the request is dropped.
- R4: An entry allocated with `allocDone` low does not retire until it is completed by writeback. An entry allocated with `allocDone` high may retire in the cycle after its allocation.
- R5: A writeback naming an occupied slot marks that slot complete. A writeback naming an unoccupied slot has no effect: a later allocation into that slot still waits for its own writeback.
- R6: Only the oldest occupied slot retires. If it is incomplete, nothing retires, even when younger slots are complete.
- R7: At most one slot retires per cycle. Complete slots drain on consecutive cycles.
- R8: While `retValid` is high, `retArch` and `retPhys` carry the retiring entry's architectural register and its new physical register.
- R9: While `retValid` is high, `freePhys` carries the retiring entry's previous physical register, not the new one.
- R10: `storeGo` is high exactly when the retiring entry was allocated with `allocStore` high.
- R11: A retired slot is cleared and freed. After a retirement from a full queue, the next allocation is granted the slot just freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| allocReq | input | 1 | Rename requests a slot |
| allocArch | input | ARCH_W | Destination architectural register |
| allocNewPhys | input | PHYS_W | Newly assigned physical register |
| allocOldPhys | input | PHYS_W | Physical register of the previous mapping |
| allocDone | input | 1 | Instruction needs no execution (idiom or eliminated move) |
| allocStore | input | 1 | Instruction is a store |
| allocGrant | output | 1 | Slot granted this cycle |
| allocIdx | output | IDX_W | Index of the granted slot |
| wbValid | input | 1 | Completion report |
| wbIdx | input | IDX_W | Slot being completed |
| retValid | output | 1 | Oldest slot retires this cycle |
| retArch | output | ARCH_W | Architectural register being committed |
| retPhys | output | PHYS_W | Physical register that becomes architectural |
| freePhys | output | PHYS_W | Stale physical register returned to the free pool |
| storeGo | output | 1 | Retiring store may write memory |

## Verification
The bench builds the queue with DEPTH 4, ARCH_W 5 and PHYS_W 6. The small depth lets a handful of allocations fill the buffer, so the refused request and the slot reused right after a retirement are both reached. The pointers also wrap several times during the run, which exercises the extra wrap bit that tells a full queue from an empty one. The register widths are wide enough that the architectural, new and old register fields each carry distinct values, so a swap between them shows up at the retire outputs.

// File: rtl/rtq_pkg.sv
package rtq_pkg;
  // strobes from control to the slot storage
  typedef struct packed {
    logic doAlloc;
    logic doRetire;
  } rtqStrobe_t;
endpackage

// File: rtl/rtq_ctrl.sv
module rtq_ctrl
  import rtq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocReq,
  input  logic             headReady,
  output rtqStrobe_t       stb,
  output logic [IDX_W-1:0] tailSlot,
  output logic [IDX_W-1:0] headSlot
);
  // pointers carry one extra wrap bit above the slot index
  logic [IDX_W:0] headPtr, tailPtr;
  logic isEmpty, isFull;

  assign headSlot = headPtr[IDX_W-1:0];
  assign tailSlot = tailPtr[IDX_W-1:0];
  assign isEmpty  = (headPtr == tailPtr);
  assign isFull   = (headSlot == tailSlot) && (headPtr[IDX_W] != tailPtr[IDX_W]);

  always_comb begin
    stb.doAlloc  = allocReq && !isFull;
    stb.doRetire = !isEmpty && headReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (stb.doAlloc)  tailPtr <= tailPtr + 1'b1;
      if (stb.doRetire) headPtr <= headPtr + 1'b1;
    end
  end
endmodule

// File: rtl/rtq_data.sv
module rtq_data
  import rtq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtqStrobe_t        stb,
  input  logic [IDX_W-1:0]  tailSlot,
  input  logic [IDX_W-1:0]  headSlot,
  input  logic [ARCH_W-1:0] allocArch,
  input  logic [PHYS_W-1:0] allocNewPhys,
  input  logic [PHYS_W-1:0] allocOldPhys,
  input  logic              allocDone,
  input  logic              allocStore,
  input  logic              wbValid,
  input  logic [IDX_W-1:0]  wbIdx,
  output logic              headReady,
  output logic [ARCH_W-1:0] headArch,
  output logic [PHYS_W-1:0] headNewPhys,
  output logic [PHYS_W-1:0] headOldPhys,
  output logic              headStore
);
  logic [DEPTH-1:0]  slotValid, slotReady;
  logic [ARCH_W-1:0] archQ    [DEPTH];
  logic [PHYS_W-1:0] newPhysQ [DEPTH];
  logic [PHYS_W-1:0] oldPhysQ [DEPTH];
  logic [DEPTH-1:0]  storeQ;

  // status bits: retire clears, writeback completes, allocation overrides
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
      slotReady <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (stb.doRetire && headSlot == IDX_W'(s)) begin
          slotValid[s] <= 1'b0;
          slotReady[s] <= 1'b0;
        end
        if (wbValid && wbIdx == IDX_W'(s) && slotValid[s])
          slotReady[s] <= 1'b1;
        if (stb.doAlloc && tailSlot == IDX_W'(s)) begin
          slotValid[s] <= 1'b1;
          slotReady[s] <= allocDone;
        end
      end
    end
  end

  // payload fields, written only on allocation
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (stb.doAlloc && tailSlot == IDX_W'(s)) begin
        archQ[s]    <= allocArch;
        newPhysQ[s] <= allocNewPhys;
        oldPhysQ[s] <= allocOldPhys;
        storeQ[s]   <= allocStore;
      end
    end
  end

  assign headReady   = slotValid[headSlot] && slotReady[headSlot];
  assign headArch    = archQ[headSlot];
  assign headNewPhys = newPhysQ[headSlot];
  assign headOldPhys = oldPhysQ[headSlot];
  assign headStore   = storeQ[headSlot];
endmodule

// File: rtl/rtq_top.sv
module rtq_top
  import rtq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 7,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocReq,
  input  logic [ARCH_W-1:0] allocArch,
  input  logic [PHYS_W-1:0] allocNewPhys,
  input  logic [PHYS_W-1:0] allocOldPhys,
  input  logic              allocDone,
  input  logic              allocStore,
  output logic              allocGrant,
  output logic [IDX_W-1:0]  allocIdx,
  input  logic              wbValid,
  input  logic [IDX_W-1:0]  wbIdx,
  output logic              retValid,
  output logic [ARCH_W-1:0] retArch,
  output logic [PHYS_W-1:0] retPhys,
  output logic [PHYS_W-1:0] freePhys,
  output logic              storeGo
);
  rtqStrobe_t       stb;
  logic [IDX_W-1:0] tailSlot, headSlot;
  logic             headReady, headStore;

  rtq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .headReady(headReady),
    .stb(stb), .tailSlot(tailSlot), .headSlot(headSlot)
  );

  rtq_data #(.DEPTH(DEPTH), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .tailSlot(tailSlot), .headSlot(headSlot),
    .allocArch(allocArch), .allocNewPhys(allocNewPhys), .allocOldPhys(allocOldPhys),
    .allocDone(allocDone), .allocStore(allocStore),
    .wbValid(wbValid), .wbIdx(wbIdx),
    .headReady(headReady), .headArch(retArch), .headNewPhys(retPhys),
    .headOldPhys(freePhys), .headStore(headStore)
  );

  assign allocGrant = stb.doAlloc;
  assign allocIdx   = tailSlot;
  assign retValid   = stb.doRetire;
  assign storeGo    = stb.doRetire && headStore;
endmodule

// File: rtl/rtq_checker.sv
module rtq_checker #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocReq,
  input logic             allocGrant,
  input logic [IDX_W-1:0] allocIdx,
  input logic             retValid,
  input logic             storeGo
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  logic [CNT_W-1:0] occ;

  // independent occupancy count from the port handshakes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occ <= '0;
    else       occ <= occ + CNT_W'(allocGrant) - CNT_W'(retValid);
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    allocGrant |-> occ != FULL_C);
  a_r11_grant_when_room: assert property (@(posedge clk) disable iff (!rstN)
    (allocReq && occ != FULL_C) |-> allocGrant);
  a_r1_no_retire_empty: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0) |-> !retValid);
  a_r10_store_needs_retire: assert property (@(posedge clk) disable iff (!rstN)
    storeGo |-> retValid);
  a_r2_index_step: assert property (@(posedge clk) disable iff (!rstN)
    allocGrant |=> allocIdx == IDX_W'($past(allocIdx) + 1'b1));
endmodule

bind rtq_top rtq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocGrant(allocGrant),
  .allocIdx(allocIdx), .retValid(retValid), .storeGo(storeGo)
);

// File: tb/rtq_top_test.sv
module rtq_top_test;
  localparam int DEPTH = 4, ARCH_W = 5, PHYS_W = 6, IDX_W = 2;

  logic clk = 0, rstN = 0;
  logic allocReq = 0, allocDone = 0, allocStore = 0, wbValid = 0;
  logic [ARCH_W-1:0] allocArch = '0;
  logic [PHYS_W-1:0] allocNewPhys = '0, allocOldPhys = '0;
  logic [IDX_W-1:0]  wbIdx = '0;
  logic allocGrant, retValid, storeGo;
  logic [IDX_W-1:0]  allocIdx;
  logic [ARCH_W-1:0] retArch;
  logic [PHYS_W-1:0] retPhys, freePhys;

  int checks = 0, failures = 0, cyc = 0;
  int logCnt = 0;
  int logArch[64], logPhys[64], logFree[64], logSt[64], logCyc[64];

  always #5 clk = ~clk;

  rtq_top #(.DEPTH(DEPTH), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)) uut (.*);

  // retire monitor, sampled mid-cycle
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN && retValid && logCnt < 64) begin
      logArch[logCnt] <= int'(retArch);
      logPhys[logCnt] <= int'(retPhys);
      logFree[logCnt] <= int'(freePhys);
      logSt[logCnt]   <= int'(storeGo);
      logCyc[logCnt]  <= cyc;
      logCnt <= logCnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic alloc(input int a, input int np, input int op, input bit done,
                       input bit st, output int idx, output int gr);
    @(negedge clk);
    #1;
    allocReq = 1; allocArch = ARCH_W'(a); allocNewPhys = PHYS_W'(np);
    allocOldPhys = PHYS_W'(op); allocDone = done; allocStore = st;
    #1;
    idx = int'(allocIdx); gr = int'(allocGrant);
    @(posedge clk);
    #1 allocReq = 0;
  endtask

  task automatic wb(input int idx);
    @(negedge clk);
    #1 wbValid = 1; wbIdx = IDX_W'(idx);
    @(posedge clk);
    #1 wbValid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 retValid", int'(retValid), 0);
    check("R1 storeGo", int'(storeGo), 0);
    check("R1 allocIdx", int'(allocIdx), 0);
  endtask

  // done-at-rename entries retire on consecutive cycles with correct fields
  task automatic t_eliminated;
    int idx, gr, base;
    base = logCnt;
    alloc(1, 10, 20, 1, 0, idx, gr); check("R2 idx0", idx, 0); check("R2 grant", gr, 1);
    alloc(2, 11, 21, 1, 1, idx, gr); check("R2 idx1", idx, 1);
    alloc(3, 12, 22, 1, 0, idx, gr); check("R2 idx2", idx, 2);
    idle(3);
    check("R4 eliminated retired", logCnt - base, 3);
    for (int k = 0; k < 3; k++) begin
      check("R8 arch", logArch[base+k], k + 1);
      check("R8 phys", logPhys[base+k], 10 + k);
      check("R9 free", logFree[base+k], 20 + k);
      check("R10 store", logSt[base+k], (k == 1) ? 1 : 0);
    end
    check("R7 consecutive", logCyc[base+1] - logCyc[base], 1);
    check("R7 consecutive2", logCyc[base+2] - logCyc[base+1], 1);
  endtask

  // younger completions wait behind an incomplete head
  task automatic t_order;
    int ia, ib, ic, gr, base;
    base = logCnt;
    alloc(4, 30, 40, 0, 1, ia, gr);
    alloc(5, 31, 41, 0, 0, ib, gr);
    alloc(6, 32, 42, 0, 0, ic, gr);
    idle(3);
    check("R4 not ready no retire", logCnt - base, 0);
    wb(ic); wb(ib); idle(3);
    check("R6 head stalls", logCnt - base, 0);
    wb(ia); idle(4);
    check("R6 drained", logCnt - base, 3);
    check("R6 order a", logArch[base], 4);
    check("R6 order b", logArch[base+1], 5);
    check("R6 order c", logArch[base+2], 6);
    check("R10 store a", logSt[base], 1);
    check("R5 wb completes", logPhys[base+2], 32);
  endtask

  // full queue refuses, a retirement frees the head slot for reuse
  task automatic t_full;
    int id[4], gr, extra, base;
    base = logCnt;
    for (int k = 0; k < 4; k++) alloc(8 + k, 50 + k, 60 + k, 0, 0, id[k], gr);
    alloc(20, 1, 2, 0, 0, extra, gr);
    check("R3 refused when full", gr, 0);
    wb(id[0]); idle(2);
    check("R11 one retired", logCnt - base, 1);
    alloc(21, 55, 56, 0, 0, extra, gr);
    check("R11 grant after free", gr, 1);
    check("R11 reuses freed slot", extra, id[0]);
    wb(id[1]); wb(id[2]); wb(id[3]); wb(extra); idle(3);
    check("R11 drained", logCnt - base, 5);
    check("R3 dropped req not stored", logArch[base+4], 21);
  endtask

  // writeback to an empty slot must not pre-complete a later entry
  task automatic t_stale_wb;
    int idx, gr, base, probe;
    base = logCnt;
    @(negedge clk); probe = int'(allocIdx);
    wb(probe); idle(1);
    alloc(7, 33, 44, 0, 0, idx, gr);
    check("R5 same slot", idx, probe);
    idle(3);
    check("R5 stale wb ignored", logCnt - base, 0);
    wb(idx); idle(2);
    check("R5 completes on own wb", logCnt - base, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rstN = 1;
        t_reset();
        t_eliminated();
        t_order();
        t_full();
        t_stale_wb();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule